// File: doc/BRIEF.md
# Joinable Two-Channel Pulse-Width Modulator

This block holds two independent 8-bit pulse-width channels. Each channel has its own period and duty values, an output polarity bit, an alignment bit that picks edge-aligned or center-aligned counting, an enable bit, and a bit that selects which of two clock-enable strobes advances its counter. The strobes come from a prescaler outside the block. Period and duty values wait in shadow registers and are adopted only at the end of a period, or at once while the channel is off, so a running waveform never gets a torn cycle.

A join input turns the two channels into one 16-bit channel. Channel 0 then supplies the upper byte of the period and duty values and channel 1 the lower byte. Channel 1's polarity, alignment, enable and strobe-select bits govern the joined channel, and its waveform leaves on output 1. Output 0 is held low. Degenerate settings give steady levels: a zero period, a zero duty, or a duty at or above the period. Both output bits are registered and follow the internal counter state by one clock.

Top module: `pwm_pair`

## Requirements
- R1: While reset is high, both outputs are driven low on the next clock, every counter is cleared and set to count upward, and no channel runs.
- R2: In edge-aligned mode (alignment bit 0) with strobes on every clock, the waveform repeats every P strobes, where P is the period. For the first D counts of each period (D is the duty) the output sits at the active level, and for the rest it sits at the inactive level. The active level is high when polarity is 1 and low when polarity is 0.
- R3: In center-aligned mode (alignment bit 1) the counter climbs from 0 to P and falls back to 0. The waveform repeats every 2·P strobes and holds the active level for 2·D of them, in one contiguous run.
- R4: With a period of zero the counter stays at zero, and the output of an enabled channel is constantly high for polarity 1 and constantly low for polarity 0.
- R5: With a nonzero period and a duty of zero, the output is constantly low for polarity 1 and constantly high for polarity 0.
- R6: With a nonzero period and a duty greater than or equal to that period, the output is constantly high for polarity 1 and constantly low for polarity 0.
- R7: A period or duty value written while the channel runs takes effect only when the current period completes.
- R8: A disabled channel drives its output low and clears its counter. Enabling it starts a new period from count 0.
- R9: A channel's counter advances on strobe A when its select bit is 0 and on strobe B when it is 1.
- R10: When joined, the 16-bit period is {per_i[0], per_i[1]} and the 16-bit duty is {dty_i[0], dty_i[1]}. Channel 1's control bits govern the joined channel, and channel 0's enable, polarity, alignment and select bits have no effect.
- R11: When joined, the 16-bit waveform appears on pwm_o[1] and pwm_o[0] is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_a_i | input | 1 | Counter strobe A |
| tick_b_i | input | 1 | Counter strobe B |
| cat_i | input | 1 | Join both channels into one 16-bit channel |
| en_i | input | 2 | Per-channel enable |
| pol_i | input | 2 | Per-channel polarity (1: active high) |
| ctr_i | input | 2 | Per-channel alignment (1: center aligned) |
| csel_i | input | 2 | Per-channel strobe select (1: strobe B) |
| per_i | input | 2x8 | Per-channel period value |
| dty_i | input | 2x8 | Per-channel duty value |
| pwm_o | output | 2 | Registered waveform outputs |

## Verification
The assertions assume that reset is applied for at least one clock before any check is relied on. They also assume the strobe inputs are plain single-cycle enables sampled at the clock edge. Beyond that, any combination of join, enable, polarity and value changes may arrive on any cycle, because the properties only bind the outputs and the counters to their registered state.

The stimulus changes configuration only at falling clock edges. Before each case it pulses enable low, so that the shadow values load at once. It then measures only over whole multiples of the waveform's repeat length, or over complete active runs, so the starting phase does not affect the expected values.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} dir_e;
  localparam int NUM_CH = 2;
endpackage

// File: rtl/pwm_tick_pick.sv
module pwm_tick_pick (
  input  logic sel_i,
  input  logic tick_a_i,
  input  logic tick_b_i,
  output logic tick_o
);
  assign tick_o = sel_i ? tick_b_i : tick_a_i;
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pair_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic         center_i,
  input  logic         pol_i,
  input  logic [W-1:0] per_i,
  input  logic [W-1:0] dty_i,
  output logic         wave_o,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] per_o
);
  logic [W-1:0] cnt_q, per_q, dty_q;
  logic         ctr_q;
  dir_e         dir_q;
  logic         idle, at_top, at_floor, load, active;

  assign idle     = !en_i || (per_q == '0);
  assign at_top   = (cnt_q == per_q - W'(1));
  assign at_floor = (cnt_q == W'(1));
  // shadow copies are refreshed while idle or when a period completes
  assign load = idle ||
                (tick_i && !ctr_q && at_top) ||
                (tick_i && ctr_q && (dir_q == DIR_DOWN) && at_floor);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
      per_q <= '0;
      dty_q <= '0;
      ctr_q <= 1'b0;
    end else begin
      if (load) begin
        per_q <= per_i;
        dty_q <= dty_i;
        ctr_q <= center_i;
      end
      if (idle) begin
        cnt_q <= '0;
        dir_q <= DIR_UP;
      end else if (tick_i) begin
        if (!ctr_q) begin
          cnt_q <= at_top ? '0 : cnt_q + W'(1);
        end else if (dir_q == DIR_UP) begin
          if (at_top) begin
            cnt_q <= per_q;
            dir_q <= DIR_DOWN;
          end else begin
            cnt_q <= cnt_q + W'(1);
          end
        end else begin
          if (at_floor) begin
            cnt_q <= '0;
            dir_q <= DIR_UP;
          end else begin
            cnt_q <= cnt_q - W'(1);
          end
        end
      end
    end
  end

  always_comb begin
    if (per_q == '0)          active = 1'b1;
    else if (dir_q == DIR_UP) active = (cnt_q < dty_q);
    else                      active = (cnt_q <= dty_q);
  end

  assign wave_o = en_i && (pol_i ? active : !active);
  assign cnt_o  = cnt_q;
  assign per_o  = per_q;
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
  import pwm_pair_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_i,
  input  logic                         tick_a_i,
  input  logic                         tick_b_i,
  input  logic                         cat_i,
  input  logic [NUM_CH-1:0]            en_i,
  input  logic [NUM_CH-1:0]            pol_i,
  input  logic [NUM_CH-1:0]            ctr_i,
  input  logic [NUM_CH-1:0]            csel_i,
  input  logic [NUM_CH-1:0][CH_W-1:0]  per_i,
  input  logic [NUM_CH-1:0][CH_W-1:0]  dty_i,
  output logic [NUM_CH-1:0]            pwm_o
);
  localparam int CAT_W = 2 * CH_W;

  logic [NUM_CH-1:0]           ch_tick, ch_wave;
  logic [NUM_CH-1:0][CH_W-1:0] ch_cnt, ch_per;
  logic                        cat_wave;
  logic [CAT_W-1:0]            cat_cnt, cat_per;
  logic [NUM_CH-1:0]           pwm_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_tick_pick u_pick (
      .sel_i    (csel_i[g]),
      .tick_a_i (tick_a_i),
      .tick_b_i (tick_b_i),
      .tick_o   (ch_tick[g])
    );
    pwm_chan #(.W(CH_W)) u_ch (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .en_i     (en_i[g] && !cat_i),
      .tick_i   (ch_tick[g]),
      .center_i (ctr_i[g]),
      .pol_i    (pol_i[g]),
      .per_i    (per_i[g]),
      .dty_i    (dty_i[g]),
      .wave_o   (ch_wave[g]),
      .cnt_o    (ch_cnt[g]),
      .per_o    (ch_per[g])
    );
  end

  // joined channel: channel 0 is the upper byte, channel 1 owns control
  pwm_chan #(.W(CAT_W)) u_cat (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .en_i     (en_i[1] && cat_i),
    .tick_i   (ch_tick[1]),
    .center_i (ctr_i[1]),
    .pol_i    (pol_i[1]),
    .per_i    ({per_i[0], per_i[1]}),
    .dty_i    ({dty_i[0], dty_i[1]}),
    .wave_o   (cat_wave),
    .cnt_o    (cat_cnt),
    .per_o    (cat_per)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pwm_q <= '0;
    end else begin
      pwm_q[0] <= cat_i ? 1'b0 : ch_wave[0];
      pwm_q[1] <= cat_i ? cat_wave : ch_wave[1];
    end
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/pwm_pair_chk.sv
module pwm_pair_chk #(
  parameter int CH_W = 8
) (
  input logic                    clk_i,
  input logic                    rst_i,
  input logic                    cat_i,
  input logic [1:0]              en_i,
  input logic [1:0]              pol_i,
  input logic [1:0]              pwm_o,
  input logic [1:0][CH_W-1:0]    ch_cnt,
  input logic [1:0][CH_W-1:0]    ch_per,
  input logic [2*CH_W-1:0]       cat_cnt,
  input logic [2*CH_W-1:0]       cat_per
);
  // R1
  reset_low_chk: assert property (@(posedge clk_i) rst_i |=> (pwm_o == 2'b00));

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (ch_cnt[0] <= ch_per[0]) && (ch_cnt[1] <= ch_per[1]));

  // R10
  cat_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    cat_cnt <= cat_per);

  // R4
  zero_per_level_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!cat_i && en_i[0] && ch_per[0] == '0) |=> (pwm_o[0] == $past(pol_i[0])));

  // R8
  off_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!en_i[0] || cat_i) |=> (!pwm_o[0] && ch_cnt[0] == '0));

  // R11
  cat_even_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    cat_i |=> !pwm_o[0]);
endmodule

bind pwm_pair pwm_pair_chk #(.CH_W(CH_W)) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .cat_i   (cat_i),
  .en_i    (en_i),
  .pol_i   (pol_i),
  .pwm_o   (pwm_o),
  .ch_cnt  (ch_cnt),
  .ch_per  (ch_per),
  .cat_cnt (cat_cnt),
  .cat_per (cat_per)
);

// File: tb/test_pwm_pair.sv
module test_pwm_pair;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit    run;
    int    ch;
    int    win;
    int    exp;
    string tag;
  } item_t;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            tick_a = 1'b1;
  logic            tick_b = 1'b0;
  logic            cat = 1'b0;
  logic [1:0]      en = '0, pol = '0, ctr = '0, csel = '0;
  logic [1:0][7:0] per = '0, dty = '0;
  logic [1:0]      pwm;

  item_t q[$];
  int    n_chk = 0, n_fail = 0, n_done = 0, n_push = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_pair i_pwm_pair (
    .clk_i(clk), .rst_i(rst), .tick_a_i(tick_a), .tick_b_i(tick_b),
    .cat_i(cat), .en_i(en), .pol_i(pol), .ctr_i(ctr), .csel_i(csel),
    .per_i(per), .dty_i(dty), .pwm_o(pwm)
  );

  initial forever @(posedge clk) tick_b <= ~tick_b;

  task automatic check(int act, int exp, string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(bit c, logic [1:0] e, logic [1:0] p, logic [1:0] ct,
                     logic [1:0] cs, logic [7:0] p0, logic [7:0] p1,
                     logic [7:0] d0, logic [7:0] d1);
    @(negedge clk);
    en = '0; cat = c; pol = p; ctr = ct; csel = cs;
    per[0] = p0; per[1] = p1; dty[0] = d0; dty[1] = d1;
    repeat (2) @(negedge clk);
    en = e;
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_item(bit run, int ch, int win, int exp, string tag);
    item_t it;
    it.run = run; it.ch = ch; it.win = win; it.exp = exp; it.tag = tag;
    q.push_back(it);
    n_push++;
    wait (n_done == n_push);
  endtask

  // monitor: pops expected items and measures the output
  initial begin
    forever begin
      item_t it;
      int    h;
      wait (q.size() > 0);
      it = q.pop_front();
      h = 0;
      if (it.run) begin
        do @(negedge clk); while (pwm[it.ch]);
        do @(negedge clk); while (!pwm[it.ch]);
        while (pwm[it.ch]) begin
          h++;
          @(negedge clk);
        end
      end else begin
        repeat (it.win) begin
          @(negedge clk);
          if (pwm[it.ch]) h++;
        end
      end
      check(h, it.exp, it.tag);
      n_done++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int h;
    repeat (3) @(negedge clk);
    check(int'(pwm), 0, "R1 reset outputs low");
    rst = 1'b0;

    // edge-aligned
    cfg(0, 2'b01, 2'b01, 2'b00, 2'b00, 8'd10, 8'd0, 8'd3, 8'd0);
    expect_item(0, 0, 100, 30, "R2 left pol1 high count");
    expect_item(1, 0, 0, 3, "R2 left pol1 run");
    cfg(0, 2'b01, 2'b00, 2'b00, 2'b00, 8'd10, 8'd0, 8'd3, 8'd0);
    expect_item(0, 0, 100, 70, "R2 left pol0 high count");

    // center-aligned
    cfg(0, 2'b10, 2'b10, 2'b10, 2'b00, 8'd0, 8'd8, 8'd0, 8'd3);
    expect_item(0, 1, 64, 24, "R3 center high count");
    expect_item(1, 1, 0, 6, "R3 center run");

    // degenerate settings
    cfg(0, 2'b01, 2'b01, 2'b00, 2'b00, 8'd0, 8'd0, 8'd4, 8'd0);
    expect_item(0, 0, 50, 50, "R4 zero period pol1");
    cfg(0, 2'b01, 2'b00, 2'b00, 2'b00, 8'd0, 8'd0, 8'd4, 8'd0);
    expect_item(0, 0, 50, 0, "R4 zero period pol0");
    cfg(0, 2'b01, 2'b01, 2'b00, 2'b00, 8'd5, 8'd0, 8'd0, 8'd0);
    expect_item(0, 0, 50, 0, "R5 zero duty pol1");
    cfg(0, 2'b01, 2'b00, 2'b01, 2'b00, 8'd5, 8'd0, 8'd0, 8'd0);
    expect_item(0, 0, 50, 50, "R5 zero duty pol0 center");
    cfg(0, 2'b01, 2'b01, 2'b00, 2'b00, 8'd10, 8'd0, 8'd12, 8'd0);
    expect_item(0, 0, 50, 50, "R6 duty above period");
    cfg(0, 2'b01, 2'b00, 2'b00, 2'b00, 8'd10, 8'd0, 8'd10, 8'd0);
    expect_item(0, 0, 50, 0, "R6 duty equal period pol0");

    // R7: duty written mid-period applies from the next period
    cfg(0, 2'b01, 2'b01, 2'b00, 2'b00, 8'd10, 8'd0, 8'd8, 8'd0);
    do @(negedge clk); while (pwm[0]);
    do @(negedge clk); while (!pwm[0]);
    h = 0;
    while (pwm[0]) begin
      h++;
      if (h == 2) dty[0] = 8'd3;
      @(negedge clk);
    end
    check(h, 8, "R7 current period keeps old duty");
    expect_item(1, 0, 0, 3, "R7 next period uses new duty");

    // R8: disabled channel stays low whatever polarity says
    cfg(0, 2'b00, 2'b00, 2'b00, 2'b00, 8'd10, 8'd10, 8'd4, 8'd4);
    expect_item(0, 0, 40, 0, "R8 disabled ch0 low");
    expect_item(0, 1, 40, 0, "R8 disabled ch1 low");

    // R9: strobe select
    cfg(0, 2'b10, 2'b10, 2'b00, 2'b10, 8'd0, 8'd4, 8'd0, 8'd1);
    expect_item(1, 1, 0, 2, "R9 strobe B run");
    cfg(0, 2'b10, 2'b10, 2'b00, 2'b00, 8'd0, 8'd4, 8'd0, 8'd1);
    expect_item(1, 1, 0, 1, "R9 strobe A run");

    // R10/R11: joined, channel 0 controls set to conflicting values
    cfg(1, 2'b10, 2'b10, 2'b01, 2'b01, 8'h01, 8'h00, 8'h00, 8'h80);
    expect_item(0, 1, 512, 256, "R10 joined left high count");
    expect_item(0, 0, 100, 0, "R11 even output low when joined");
    cfg(1, 2'b10, 2'b10, 2'b10, 2'b00, 8'h01, 8'h00, 8'h00, 8'h40);
    expect_item(0, 1, 1024, 256, "R10 joined center high count");
    expect_item(1, 1, 0, 128, "R10 joined center run");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule